// File: doc/BRIEF.md
# Monochrome Bitmap Pixel Plotter

This block changes one pixel of a 256-row by 512-column, one-bit-per-pixel screen image. The image sits in a private buffer of 8192 words of 16 bits, sixteen horizontally adjacent pixels packed into each word. A requester presents a row, a column and an ink value (1 paints black, 0 paints white) with a request strobe. The block then performs a read-modify-write on the word that holds that pixel. It flips nothing but the selected bit and tells the requester when the word is back in the buffer.

The handshake is a request input, a busy flag and a one-cycle done pulse. Coordinates outside the screen are refused with a one-cycle error pulse, and the buffer is not touched. A separate read-only port with one cycle of latency lets a checker look at any buffer word without disturbing a plot in progress. Buffer contents are zero at power-up and are not cleared by reset.

Top module: `pix_plot_top`

## Requirements
- R1: The pixel at (row, col) lives in buffer word row*32 + floor(col/16), so every row spans 32 consecutive words, (0,16) maps to word 1, (1,0) maps to word 32 and (255,0) maps to word 8160.
- R2: Inside its word, the pixel is bit col mod 16 (bit 0 is the least significant bit); after a plot that bit equals the ink input, 1 for black and 0 for white.
- R3: The other 15 bits of the modified word, and every other word of the buffer, keep their previous values.
- R4: A request is taken only while the block is idle; a request raised while busy is ignored and produces neither a write nor a second done pulse.
- R5: After the clock edge that accepts a request, busy is high for exactly four cycles. Done is high only in the fourth of them, for exactly one cycle.
- R6: Each accepted request produces exactly one buffer write, in the cycle just before the done pulse, after the word has been read one cycle earlier.
- R7: A request with row of 256 or above, or column of 512 or above, raises error for exactly the one cycle after the accepting edge. Busy and done stay low, and no buffer word changes.
- R8: While reset is held and in the first cycle after it, busy, done and error are low.
- R9: The read-only port returns the buffer word at its address one clock cycle after the address is applied.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset of the control state |
| plot_req_i | input | 1 | Plot request strobe, sampled while idle |
| plot_row_i | input | 9 | Pixel row, valid range 0..255 |
| plot_col_i | input | 10 | Pixel column, valid range 0..511 |
| plot_ink_i | input | 1 | Pixel value to store: 1 black, 0 white |
| plot_busy_o | output | 1 | High while a plot is in progress |
| plot_done_o | output | 1 | One-cycle pulse when the modified word is written back |
| plot_err_o | output | 1 | One-cycle pulse when a request is refused for range |
| peek_addr_i | input | 13 | Word address for the read-only port |
| peek_data_o | output | 16 | Buffer word at peek_addr_i, one cycle later |

## Verification
The bench targets the seams of the word layout: bit 0 against bit 15, the first and last word of a row, the last word of the buffer and a clear that follows a set in the same word. A design that swapped the bit order or divided the column wrongly would land the pixel in another word or bit, and one that rebuilt the word instead of merging it would wipe the neighbouring pixels. Row 256 and column 512 are driven because a design that truncates coordinates would alias them onto word 0 or onto the wrong word and corrupt it. A request held up during a plot checks that a second write or a second done pulse never appears.

// File: rtl/pix_pkg.sv
package pix_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_READ,
    ST_MODIFY,
    ST_WRITE,
    ST_DONE
  } plot_state_e;

  // Linear word index of a pixel in a row-major packed bitmap.
  function automatic int word_index(input int row, input int col,
                                    input int words_per_row, input int word_w);
    return row * words_per_row + col / word_w;
  endfunction

  // Bit position of a pixel inside its packed word.
  function automatic int bit_index(input int col, input int word_w);
    return col % word_w;
  endfunction

endpackage

// File: rtl/pix_mem.sv
module pix_mem #(
  parameter int DW    = 16,
  parameter int DEPTH = 8192,
  localparam int AW   = $clog2(DEPTH)
) (
  input  logic          clk,
  input  logic [AW-1:0] addr,
  input  logic          we,
  input  logic [DW-1:0] wdata,
  output logic [DW-1:0] rdata,
  input  logic [AW-1:0] peek_addr,
  output logic [DW-1:0] peek_data
);

  logic [DW-1:0] store [DEPTH];

  // Power-up image is blank.
  initial begin
    for (int i = 0; i < DEPTH; i++) store[i] = '0;
  end

  always_ff @(posedge clk) begin
    if (we) store[addr] <= wdata;
    rdata     <= store[addr];
    peek_data <= store[peek_addr];
  end

endmodule

// File: rtl/pix_ctrl.sv
module pix_ctrl
  import pix_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        req,
  input  logic        in_range,
  output logic        accept,
  output logic        mod_en,
  output logic        mem_we,
  output logic        busy_o,
  output logic        done_o,
  output logic        err_o
);

  plot_state_e state_q, state_d;
  logic        reject;
  logic        err_q;

  assign accept = (state_q == ST_IDLE) && req && in_range;
  assign reject = (state_q == ST_IDLE) && req && !in_range;

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      ST_IDLE:   if (accept) state_d = ST_READ;
      ST_READ:   state_d = ST_MODIFY;
      ST_MODIFY: state_d = ST_WRITE;
      ST_WRITE:  state_d = ST_DONE;
      ST_DONE:   state_d = ST_IDLE;
      default:   state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      err_q   <= 1'b0;
    end else begin
      state_q <= state_d;
      err_q   <= reject;
    end
  end

  assign mod_en = (state_q == ST_MODIFY);
  assign mem_we = (state_q == ST_WRITE);
  assign busy_o = (state_q != ST_IDLE);
  assign done_o = (state_q == ST_DONE);
  assign err_o  = err_q;

  // R5: acceptance raises busy on the next cycle
  p_accept_busy_r5: assert property (@(posedge clk) disable iff (!rst_n)
    accept |=> busy_o);

  // R5: done is a single-cycle pulse
  p_done_pulse_r5: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |=> !done_o);

  // R6: the write is followed directly by done
  p_write_then_done_r6: assert property (@(posedge clk) disable iff (!rst_n)
    mem_we |=> done_o);

  // R7: a refused request leaves the block idle and quiet
  p_err_quiet_r7: assert property (@(posedge clk) disable iff (!rst_n)
    err_o |-> (!busy_o && !mem_we && !done_o));

  // R7: error is a single-cycle pulse unless refused again
  p_err_pulse_r7: assert property (@(posedge clk) disable iff (!rst_n)
    err_o |-> $past(req && !in_range));

endmodule

// File: rtl/pix_rmw.sv
module pix_rmw #(
  parameter int ROWS  = 256,
  parameter int COLS  = 512,
  parameter int DW    = 16,
  localparam int WPR  = COLS / DW,
  localparam int AW   = $clog2(ROWS * WPR),
  localparam int BW   = $clog2(DW),
  localparam int RIW  = $clog2(ROWS) + 1,
  localparam int CIW  = $clog2(COLS) + 1
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           accept,
  input  logic           mod_en,
  input  logic           mem_we,
  input  logic           busy,
  input  logic [RIW-1:0] row,
  input  logic [CIW-1:0] col,
  input  logic           ink,
  input  logic [DW-1:0]  rd_word,
  output logic [AW-1:0]  mem_addr,
  output logic [DW-1:0]  mem_wdata
);

  logic [AW-1:0] addr_q;
  logic [BW-1:0] bit_q;
  logic          ink_q;
  logic [DW-1:0] wr_q;
  logic [DW-1:0] snap_q;
  logic [DW-1:0] sel_mask;

  function automatic logic [DW-1:0] merge_pixel(input logic [DW-1:0] word,
                                                input logic [DW-1:0] mask,
                                                input logic          val);
    return val ? (word | mask) : (word & ~mask);
  endfunction

  assign sel_mask = DW'(1) << bit_q;

  always_ff @(posedge clk) begin
    if (accept) begin
      addr_q <= AW'(pix_pkg::word_index(int'(row), int'(col), WPR, DW));
      bit_q  <= BW'(pix_pkg::bit_index(int'(col), DW));
      ink_q  <= ink;
    end
    if (mod_en) begin
      snap_q <= rd_word;
      wr_q   <= merge_pixel(rd_word, sel_mask, ink_q);
    end
  end

  assign mem_addr  = addr_q;
  assign mem_wdata = wr_q;

  // R3: only the selected bit may differ from the word that was read
  p_keep_others_r3: assert property (@(posedge clk) disable iff (!rst_n)
    mem_we |-> (((mem_wdata ^ snap_q) & ~sel_mask) == '0));

  // R2: the written bit carries the requested ink
  p_bit_value_r2: assert property (@(posedge clk) disable iff (!rst_n)
    mem_we |-> ((mem_wdata & sel_mask) == (ink_q ? sel_mask : '0)));

  // R1: the buffer address holds still for the whole operation
  p_addr_stable_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && $past(busy)) |-> $stable(mem_addr));

endmodule

// File: rtl/pix_plot_top.sv
module pix_plot_top #(
  parameter int ROWS  = 256,
  parameter int COLS  = 512,
  parameter int DW    = 16,
  localparam int WPR  = COLS / DW,
  localparam int DEPTH = ROWS * WPR,
  localparam int AW   = $clog2(DEPTH),
  localparam int RIW  = $clog2(ROWS) + 1,
  localparam int CIW  = $clog2(COLS) + 1
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           plot_req_i,
  input  logic [RIW-1:0] plot_row_i,
  input  logic [CIW-1:0] plot_col_i,
  input  logic           plot_ink_i,
  output logic           plot_busy_o,
  output logic           plot_done_o,
  output logic           plot_err_o,
  input  logic [AW-1:0]  peek_addr_i,
  output logic [DW-1:0]  peek_data_o
);

  logic          in_range;
  logic          accept;
  logic          mod_en;
  logic          mem_we;
  logic [AW-1:0] mem_addr;
  logic [DW-1:0] mem_wdata;
  logic [DW-1:0] mem_rdata;

  assign in_range = (int'(plot_row_i) < ROWS) && (int'(plot_col_i) < COLS);

  pix_ctrl u_ctrl (
    .clk      (clk),
    .rst_n    (rst_n),
    .req      (plot_req_i),
    .in_range (in_range),
    .accept   (accept),
    .mod_en   (mod_en),
    .mem_we   (mem_we),
    .busy_o   (plot_busy_o),
    .done_o   (plot_done_o),
    .err_o    (plot_err_o)
  );

  pix_rmw #(.ROWS(ROWS), .COLS(COLS), .DW(DW)) u_rmw (
    .clk       (clk),
    .rst_n     (rst_n),
    .accept    (accept),
    .mod_en    (mod_en),
    .mem_we    (mem_we),
    .busy      (plot_busy_o),
    .row       (plot_row_i),
    .col       (plot_col_i),
    .ink       (plot_ink_i),
    .rd_word   (mem_rdata),
    .mem_addr  (mem_addr),
    .mem_wdata (mem_wdata)
  );

  pix_mem #(.DW(DW), .DEPTH(DEPTH)) u_mem (
    .clk       (clk),
    .addr      (mem_addr),
    .we        (mem_we),
    .wdata     (mem_wdata),
    .rdata     (mem_rdata),
    .peek_addr (peek_addr_i),
    .peek_data (peek_data_o)
  );

  // R4: no write happens unless a plot is under way
  p_write_needs_busy_r4: assert property (@(posedge clk) disable iff (!rst_n)
    mem_we |-> plot_busy_o);

  // R7: an out-of-range request never starts a plot
  p_range_gate_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (plot_req_i && !in_range) |=> !($rose(plot_busy_o)));

endmodule

// File: tb/sim_pix_plot_top.sv
module sim_pix_plot_top;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req = 1'b0;
  logic [8:0]  row = '0;
  logic [9:0]  col = '0;
  logic        ink = 1'b0;
  logic        busy, done, err;
  logic [12:0] paddr = '0;
  logic [15:0] pdata;

  int n_checks = 0;
  int n_fail   = 0;

  logic [15:0] shadow [8192];

  always #4 clk = ~clk;  // 125 MHz

  pix_plot_top u0 (
    .clk(clk), .rst_n(rst_n), .plot_req_i(req), .plot_row_i(row),
    .plot_col_i(col), .plot_ink_i(ink), .plot_busy_o(busy),
    .plot_done_o(done), .plot_err_o(err), .peek_addr_i(paddr),
    .peek_data_o(pdata)
  );

  typedef struct packed {
    logic [8:0]  r;
    logic [9:0]  c;
    logic        k;
    logic [12:0] a;   // expected word, worked out by hand
    logic [3:0]  b;   // expected bit, worked out by hand
  } vec_t;

  localparam vec_t VEC [12] = '{
    '{9'd0,   10'd0,   1'b1, 13'd0,    4'd0},
    '{9'd0,   10'd15,  1'b1, 13'd0,    4'd15},
    '{9'd0,   10'd16,  1'b1, 13'd1,    4'd0},
    '{9'd1,   10'd0,   1'b1, 13'd32,   4'd0},
    '{9'd255, 10'd0,   1'b1, 13'd8160, 4'd0},
    '{9'd255, 10'd511, 1'b1, 13'd8191, 4'd15},
    '{9'd0,   10'd0,   1'b0, 13'd0,    4'd0},
    '{9'd100, 10'd37,  1'b1, 13'd3202, 4'd5},
    '{9'd100, 10'd38,  1'b1, 13'd3202, 4'd6},
    '{9'd100, 10'd37,  1'b0, 13'd3202, 4'd5},
    '{9'd17,  10'd300, 1'b1, 13'd562,  4'd12},
    '{9'd255, 10'd511, 1'b0, 13'd8191, 4'd15}
  };

  task automatic check(input string tag, input int act, input int exp);
    n_checks++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic peek(input logic [12:0] a, output logic [15:0] d);
    @(negedge clk) paddr = a;
    @(negedge clk) d = pdata;
  endtask

  // Issue one in-range plot and time it; returns cycles to done.
  task automatic plot(input logic [8:0] r, input logic [9:0] c, input logic k,
                      output int lat);
    @(negedge clk);
    req = 1'b1; row = r; col = c; ink = k;
    @(negedge clk);
    req = 1'b0;
    lat = 1;
    check("R5 busy after accept", int'(busy), 1);
    while (!done && lat < 20) begin
      @(negedge clk);
      lat++;
      if (!done) check("R5 busy while working", int'(busy), 1);
    end
    @(negedge clk);
    check("R5 done one cycle", int'(done), 0);
    check("R5 busy released", int'(busy), 0);
  endtask

  initial begin
    #(8 * 100000);
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end

  initial begin
    logic [15:0] w;
    int lat;
    for (int i = 0; i < 8192; i++) shadow[i] = '0;

    // R8: quiet outputs in and right after reset
    repeat (3) @(negedge clk);
    check("R8 busy in reset", int'(busy), 0);
    check("R8 done in reset", int'(done), 0);
    check("R8 err in reset", int'(err), 0);
    rst_n = 1'b1;
    @(negedge clk);
    check("R8 quiet after reset", int'({busy, done, err}), 0);

    // R1 R2 R3 R5 R9: table walk
    for (int i = 0; i < 12; i++) begin
      plot(VEC[i].r, VEC[i].c, VEC[i].k, lat);
      check($sformatf("R5 latency vec%0d", i), lat, 4);
      if (VEC[i].k) shadow[VEC[i].a] = shadow[VEC[i].a] | (16'h1 << VEC[i].b);
      else          shadow[VEC[i].a] = shadow[VEC[i].a] & ~(16'h1 << VEC[i].b);
      peek(VEC[i].a, w);
      check($sformatf("R1 R2 R3 R9 word vec%0d", i), int'(w), int'(shadow[VEC[i].a]));
    end
    // R3: neighbouring words untouched
    peek(13'd2, w);    check("R3 word 2 untouched", int'(w), 0);
    peek(13'd31, w);   check("R3 word 31 untouched", int'(w), 0);
    peek(13'd3203, w); check("R3 word 3203 untouched", int'(w), 0);
    peek(13'd0, w);    check("R2 word 0 after clear", int'(w), 16'h8000);

    // R7: row out of range
    @(negedge clk);
    req = 1'b1; row = 9'd256; col = 10'd0; ink = 1'b1;
    @(negedge clk);
    req = 1'b0;
    check("R7 err after bad row", int'(err), 1);
    check("R7 no busy on bad row", int'(busy), 0);
    @(negedge clk);
    check("R7 err pulse ends", int'(err), 0);
    check("R7 no done", int'(done), 0);
    peek(13'd0, w); check("R7 word 0 unchanged", int'(w), 16'h8000);

    // R7: column out of range
    @(negedge clk);
    req = 1'b1; row = 9'd3; col = 10'd512; ink = 1'b1;
    @(negedge clk);
    req = 1'b0;
    check("R7 err after bad col", int'(err), 1);
    check("R7 no busy on bad col", int'(busy), 0);
    peek(13'd96, w); check("R7 word 96 unchanged", int'(w), 0);

    // R4: request during busy is ignored
    @(negedge clk);
    req = 1'b1; row = 9'd10; col = 10'd0; ink = 1'b1;
    @(negedge clk);
    check("R4 first accepted", int'(busy), 1);
    col = 10'd1;  // keep req high with a new pixel while busy
    @(negedge clk);
    req = 1'b0;
    lat = 2;
    while (!done && lat < 20) begin @(negedge clk); lat++; end
    check("R4 R5 first done at 4", lat, 4);
    @(negedge clk);
    check("R4 no second op", int'(busy), 0);
    repeat (6) begin
      @(negedge clk);
      check("R4 no extra done", int'(done), 0);
    end
    peek(13'd320, w); check("R4 only first pixel set", int'(w), 16'h0001);

    // R6: back-to-back plots in one word both land
    plot(9'd10, 10'd2, 1'b1, lat);
    plot(9'd10, 10'd3, 1'b1, lat);
    peek(13'd320, w); check("R6 R3 merged word", int'(w), 16'h000D);

    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end

endmodule